// File: doc/BRIEF.md
# Audio Frame Sequencer Controller

This block paces the slow modulation units of a game-console style audio engine. A per-CPU-cycle enable advances a frame counter. At fixed counts the counter emits quarter-frame and half-frame strobes, which drive the envelope, length and sweep logic that sits elsewhere. In four-step mode the counter also raises a frame interrupt at the end of each frame. In five-step mode it runs a longer frame and raises no interrupt.

Software selects the sequence and the interrupt inhibit by writing a control byte. The write does not act at once. It is held in a pending copy and takes over after three or four enabled CPU cycles, with the count chosen by a CPU-cycle parity bit. On that cycle the frame counter restarts from zero. Choosing the longer sequence also fires one quarter and one half strobe straight away. The interrupt output merges the frame flag with an external interrupt request from a neighbouring sample-playback unit.

Top module: `frame_seq_ctrl`

## Requirements
- R1: After reset the strobes and the frame flag are low, the parity bit is 0, the four-step sequence is live with inhibit clear, and no write is pending.
- R2: In four-step mode, counting enabled cycles from a restart, a quarter strobe fires at counts STEP1_CYC, STEP2_CYC, STEP3_CYC and STEP4_CYC. A half strobe fires together with it at STEP2_CYC and STEP4_CYC, and the frame wraps after STEP4_CYC.
- R3: The STEP4_CYC step of four-step mode sets the frame flag unless the live inhibit bit is 1.
- R4: In five-step mode a quarter strobe fires at STEP1_CYC, STEP2_CYC, STEP3_CYC and STEP5_CYC, with a half strobe at STEP2_CYC and STEP5_CYC. Nothing fires at STEP4_CYC, the frame wraps after STEP5_CYC, and the frame flag is never set.
- R5: On a write, bit 7 of mode_wdata (1 = five-step) and bit 6 (1 = inhibit) go into a pending copy. They become live on the 3rd enabled cycle after the write if the parity bit was 0 at the write, or on the 4th if it was 1. On that cycle the counter restarts at zero and takes no ordinary step.
- R6: When a five-step setting becomes live, one quarter and one half strobe fire on that same cycle. A four-step setting becoming live fires none.
- R7: A write with bit 6 set clears the frame flag on that cycle. The clear wins over a frame-flag set that falls in the same cycle.
- R8: irq_out is high whenever ext_irq is high, or when the frame flag is high and the live inhibit bit is 0.
- R9: When cpu_tick is low, the counter, the delay and the parity hold, no strobe fires, and the frame flag changes only through a write. The parity bit toggles on every enabled cycle.
- R10: A write while another is still pending replaces the pending values and restarts the delay, so the earlier setting never becomes live.
- R11: Strobes last one clock, and a half strobe never fires without a quarter strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | One-clock enable marking a CPU cycle |
| mode_wr | input | 1 | Write strobe for the mode/inhibit byte |
| mode_wdata | input | 8 | Written byte; bit 7 selects five-step, bit 6 inhibits the frame flag |
| ext_irq | input | 1 | Interrupt request from the sample-playback unit |
| qtr_clk | output | 1 | Quarter-frame strobe |
| half_clk | output | 1 | Half-frame strobe |
| frame_irq_flag | output | 1 | Frame interrupt pending flag |
| irq_out | output | 1 | Combined interrupt line |

## Verification
Two collisions are forced on purpose. In the first, the bench watches its own model until the next enabled cycle will be the last four-step step. It then issues an inhibiting write on exactly that cycle, so the frame-flag set and the write's clear land together; the flag must stay low while both strobes still fire. In the second, a write arrives while another is pending, so the reload of the delay meets its countdown, and the earlier five-step setting must never produce its burst of strobes. Every cycle of the run is also compared against an independent cycle model, with the parity-dependent delay measured from a known parity after reset.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic {
    SEQ_FOUR = 1'b0,
    SEQ_FIVE = 1'b1
  } seq_mode_e;

  typedef struct packed {
    seq_mode_e mode;
    logic      inhibit;
  } mode_cfg_t;

  // Bit positions inside the written control byte
  localparam int MODE_BIT = 7;
  localparam int INH_BIT  = 6;

  // Apply delay, in enabled cycles, chosen by parity at write time
  localparam int DLY_EVEN = 3;
  localparam int DLY_ODD  = 4;
  localparam int DLY_W    = $clog2(DLY_ODD + 1);

endpackage

// File: rtl/frame_seq_pending.sv
module frame_seq_pending
  import frame_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_en,
  input  logic      wr_en,
  input  mode_cfg_t wr_cfg,
  output logic      apply_o,
  output mode_cfg_t cfg_o
);

  logic             pend_q, pend_d;
  logic             par_q, par_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  mode_cfg_t        cfg_q, cfg_d;

  // Next state: a write reloads the delay; otherwise enabled cycles count it down
  always_comb begin
    pend_d  = pend_q;
    par_d   = par_q;
    dly_d   = dly_q;
    cfg_d   = cfg_q;
    apply_o = 1'b0;
    if (tick_en) begin
      par_d = ~par_q;
    end
    if (wr_en) begin
      cfg_d  = wr_cfg;
      pend_d = 1'b1;
      dly_d  = par_q ? DLY_W'(DLY_ODD) : DLY_W'(DLY_EVEN);
    end else if (tick_en && pend_q) begin
      dly_d = dly_q - DLY_W'(1);
      if (dly_q == DLY_W'(1)) begin
        pend_d  = 1'b0;
        apply_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      par_q  <= 1'b0;
      dly_q  <= '0;
      cfg_q  <= '{mode: SEQ_FOUR, inhibit: 1'b0};
    end else begin
      pend_q <= pend_d;
      par_q  <= par_d;
      dly_q  <= dly_d;
      cfg_q  <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/frame_seq_counter.sv
module frame_seq_counter
  import frame_seq_pkg::*;
#(
  parameter int STEP1_CYC = 7457,
  parameter int STEP2_CYC = 14913,
  parameter int STEP3_CYC = 22371,
  parameter int STEP4_CYC = 29829,
  parameter int STEP5_CYC = 37281
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_en,
  input  logic      apply_i,
  input  mode_cfg_t cfg_i,
  output logic      qtr_o,
  output logic      half_o,
  output logic      set_irq_o,
  output logic      live_inh_o
);

  localparam int N_STEPS = 5;
  localparam int CNT_W   = $clog2(STEP5_CYC + 1);
  localparam int STEP_T [N_STEPS] = '{STEP1_CYC, STEP2_CYC, STEP3_CYC, STEP4_CYC, STEP5_CYC};

  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_inc;
  mode_cfg_t          live_q, live_d;
  logic               qtr_q, qtr_d, half_q, half_d;
  logic [N_STEPS-1:0] hit;
  logic               last_hit, qtr_hit, half_hit;

  assign cnt_inc = cnt_q + CNT_W'(1);

  // One comparator per step position
  generate
    for (genvar g = 0; g < N_STEPS; g++) begin : g_step
      assign hit[g] = (cnt_inc == CNT_W'(STEP_T[g]));
    end
  endgenerate

  always_comb begin
    last_hit  = (live_q.mode == SEQ_FIVE) ? hit[4] : hit[3];
    qtr_hit   = (|hit[2:0]) | last_hit;
    half_hit  = hit[1] | last_hit;
    cnt_d     = cnt_q;
    live_d    = live_q;
    qtr_d     = 1'b0;
    half_d    = 1'b0;
    set_irq_o = 1'b0;
    if (apply_i) begin
      live_d = cfg_i;
      cnt_d  = '0;
      qtr_d  = (cfg_i.mode == SEQ_FIVE);
      half_d = (cfg_i.mode == SEQ_FIVE);
    end else if (tick_en) begin
      cnt_d     = last_hit ? '0 : cnt_inc;
      qtr_d     = qtr_hit;
      half_d    = half_hit;
      set_irq_o = last_hit && (live_q.mode == SEQ_FOUR) && !live_q.inhibit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      live_q <= '{mode: SEQ_FOUR, inhibit: 1'b0};
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      live_q <= live_d;
      qtr_q  <= qtr_d;
      half_q <= half_d;
    end
  end

  assign qtr_o      = qtr_q;
  assign half_o     = half_q;
  assign live_inh_o = live_q.inhibit;

endmodule

// File: rtl/frame_seq_irq.sv
module frame_seq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_i,
  input  logic live_inh_i,
  input  logic ext_irq_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q, flag_d;

  // Clear from an inhibiting write outranks a same-cycle set
  always_comb begin
    flag_d = flag_q;
    if (clr_i) begin
      flag_d = 1'b0;
    end else if (set_i) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = ext_irq_i | (flag_q & ~live_inh_i);

endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
#(
  parameter int STEP1_CYC = 7457,
  parameter int STEP2_CYC = 14913,
  parameter int STEP3_CYC = 22371,
  parameter int STEP4_CYC = 29829,
  parameter int STEP5_CYC = 37281
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_tick,
  input  logic       mode_wr,
  input  logic [7:0] mode_wdata,
  input  logic       ext_irq,
  output logic       qtr_clk,
  output logic       half_clk,
  output logic       frame_irq_flag,
  output logic       irq_out
);

  mode_cfg_t wr_cfg;
  mode_cfg_t pend_cfg;
  logic      apply_w;
  logic      set_irq_w;
  logic      live_inh_w;
  logic      clr_w;
  logic      unused_wdata_bits;

  assign wr_cfg.mode       = seq_mode_e'(mode_wdata[MODE_BIT]);
  assign wr_cfg.inhibit    = mode_wdata[INH_BIT];
  assign clr_w             = mode_wr & mode_wdata[INH_BIT];
  assign unused_wdata_bits = ^mode_wdata[5:0];

  frame_seq_pending u_pending (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (cpu_tick),
    .wr_en   (mode_wr),
    .wr_cfg  (wr_cfg),
    .apply_o (apply_w),
    .cfg_o   (pend_cfg)
  );

  frame_seq_counter #(
    .STEP1_CYC (STEP1_CYC),
    .STEP2_CYC (STEP2_CYC),
    .STEP3_CYC (STEP3_CYC),
    .STEP4_CYC (STEP4_CYC),
    .STEP5_CYC (STEP5_CYC)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (cpu_tick),
    .apply_i    (apply_w),
    .cfg_i      (pend_cfg),
    .qtr_o      (qtr_clk),
    .half_o     (half_clk),
    .set_irq_o  (set_irq_w),
    .live_inh_o (live_inh_w)
  );

  frame_seq_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_w),
    .set_i      (set_irq_w),
    .live_inh_i (live_inh_w),
    .ext_irq_i  (ext_irq),
    .flag_o     (frame_irq_flag),
    .irq_o      (irq_out)
  );

endmodule

// File: rtl/frame_seq_ctrl_chk.sv
module frame_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_tick,
  input logic       mode_wr,
  input logic [7:0] mode_wdata,
  input logic       ext_irq,
  input logic       qtr_clk,
  input logic       half_clk,
  input logic       frame_irq_flag,
  input logic       irq_out
);

  AST_HALF_NEEDS_QTR: assert property (@(posedge clk) disable iff (!rst_n)
    half_clk |-> qtr_clk); // R11

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_tick |=> (!qtr_clk && !half_clk)); // R9

  AST_IDLE_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_tick && !mode_wr) |=> $stable(frame_irq_flag)); // R9

  AST_INH_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata[6]) |=> !frame_irq_flag); // R7

  AST_EXT_REACHES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |-> irq_out); // R8

  AST_FLAG_RISE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq_flag) |-> (qtr_clk && half_clk)); // R3

endmodule

bind frame_seq_ctrl frame_seq_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_tick       (cpu_tick),
  .mode_wr        (mode_wr),
  .mode_wdata     (mode_wdata),
  .ext_irq        (ext_irq),
  .qtr_clk        (qtr_clk),
  .half_clk       (half_clk),
  .frame_irq_flag (frame_irq_flag),
  .irq_out        (irq_out)
);

// File: tb/frame_seq_ctrl_tb_top.sv
module frame_seq_ctrl_tb_top;

  localparam int S1 = 8;
  localparam int S2 = 16;
  localparam int S3 = 24;
  localparam int S4 = 32;
  localparam int S5 = 40;

  logic       clk;
  logic       rst_n;
  logic       cpu_tick;
  logic       mode_wr;
  logic [7:0] mode_wdata;
  logic       ext_irq;
  logic       qtr_clk, half_clk, frame_irq_flag, irq_out;

  int    n_cmp;
  int    n_bad;
  bit    done;
  string cur_req;

  frame_seq_ctrl #(
    .STEP1_CYC (S1), .STEP2_CYC (S2), .STEP3_CYC (S3),
    .STEP4_CYC (S4), .STEP5_CYC (S5)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_tick       (cpu_tick),
    .mode_wr        (mode_wr),
    .mode_wdata     (mode_wdata),
    .ext_irq        (ext_irq),
    .qtr_clk        (qtr_clk),
    .half_clk       (half_clk),
    .frame_irq_flag (frame_irq_flag),
    .irq_out        (irq_out)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // Reference model state, written from the requirements
  typedef struct { bit q; bit h; bit f; bit ic; } exp_t;
  exp_t sb_q[$];
  int   m_cnt, m_dly;
  bit   m_mode, m_inh, m_pmode, m_pinh, m_pend, m_par, m_flag;

  // Driver side: predicts each edge and pushes the expected outputs
  always @(posedge clk) begin
    exp_t e;
    bit   eq, eh, setf, app;
    eq = 0; eh = 0; setf = 0; app = 0;
    if (!rst_n) begin
      m_cnt = 0; m_dly = 0; m_mode = 0; m_inh = 0; m_pmode = 0;
      m_pinh = 0; m_pend = 0; m_par = 0; m_flag = 0;
    end else begin
      if (cpu_tick) begin
        if (m_pend && !mode_wr) begin
          m_dly = m_dly - 1;
          if (m_dly == 0) begin
            m_pend = 0; app = 1; m_mode = m_pmode; m_inh = m_pinh; m_cnt = 0;
            eq = m_mode; eh = m_mode;
          end
        end
        if (!app) begin
          m_cnt = m_cnt + 1;
          if (m_cnt == S1 || m_cnt == S3) eq = 1;
          if (m_cnt == S2) begin eq = 1; eh = 1; end
          if (!m_mode && m_cnt == S4) begin eq = 1; eh = 1; setf = !m_inh; m_cnt = 0; end
          if (m_mode && m_cnt == S5) begin eq = 1; eh = 1; m_cnt = 0; end
        end
      end
      if (mode_wr) begin
        m_pmode = mode_wdata[7]; m_pinh = mode_wdata[6]; m_pend = 1;
        m_dly = m_par ? 4 : 3;
      end
      if (mode_wr && mode_wdata[6]) m_flag = 0;
      else if (setf) m_flag = 1;
      if (cpu_tick) m_par = !m_par;
    end
    e.q = eq; e.h = eh; e.f = m_flag; e.ic = m_flag && !m_inh;
    sb_q.push_back(e);
  end

  // Monitor side: pops one prediction per cycle, away from the edge
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_cmp++;
      if ({qtr_clk, half_clk, frame_irq_flag, irq_out} !==
          {e.q, e.h, e.f, e.ic | ext_irq}) begin
        n_bad++;
        $display("FAIL %s scoreboard: actual q/h/f/irq=%b expected=%b at %0t", cur_req,
                 {qtr_clk, half_clk, frame_irq_flag, irq_out},
                 {e.q, e.h, e.f, e.ic | ext_irq}, $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s directed: actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  // Sets the inputs used by the next edge, returns just after that edge
  task automatic drv(input bit t, input bit w, input logic [7:0] d);
    cpu_tick = t; mode_wr = w; mode_wdata = d;
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cpu_tick = 0; mode_wr = 0; mode_wdata = '0; ext_irq = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {qtr_clk, half_clk, frame_irq_flag, irq_out}, 0);
  endtask

  // Ticks until a quarter strobe appears; returns the number of edges taken
  task automatic wait_qtr(output int got);
    got = -1;
    for (int n = 1; n <= 10; n++) begin
      drv(1, 0, 8'h00);
      @(negedge clk);
      if (qtr_clk) begin
        got = n;
        chk("R6", half_clk, 1);
        break;
      end
    end
  endtask

  initial begin
    int got;
    n_cmp = 0; n_bad = 0; done = 0;
    cur_req = "R1";
    do_reset();

    // R5: write at parity 0 applies on the 3rd enabled cycle
    cur_req = "R5";
    drv(1, 1, 8'h80);
    wait_qtr(got);
    chk("R5", got, 3);

    // R4: five-step frames never set the flag
    cur_req = "R4";
    for (int i = 0; i < 90; i++) drv(1, 0, 8'h00);
    @(negedge clk);
    chk("R4", frame_irq_flag, 0);

    // R5: write at parity 1 applies on the 4th enabled cycle
    cur_req = "R5";
    do_reset();
    drv(1, 0, 8'h00);
    drv(1, 1, 8'h80);
    wait_qtr(got);
    chk("R5", got, 4);

    // R6/R2/R3: return to four-step, flag set at frame end
    cur_req = "R2";
    drv(1, 1, 8'h00);
    for (int i = 0; i < 75; i++) drv(1, 0, 8'h00);
    @(negedge clk);
    chk("R3", frame_irq_flag, 1);

    // R7: inhibiting write clears the flag at once
    cur_req = "R7";
    drv(1, 1, 8'h40);
    @(negedge clk);
    chk("R7", frame_irq_flag, 0);
    cur_req = "R3";
    for (int i = 0; i < 70; i++) drv(1, 0, 8'h00);
    @(negedge clk);
    chk("R3", frame_irq_flag, 0);

    // Clear inhibit, then collide an inhibiting write with the last step
    cur_req = "R7";
    drv(1, 1, 8'h00);
    while (!(m_cnt == S4 - 1 && !m_pend && !m_mode && !m_inh)) drv(1, 0, 8'h00);
    drv(1, 1, 8'h40);
    @(negedge clk);
    chk("R7", frame_irq_flag, 0);
    chk("R2", qtr_clk && half_clk, 1);

    // R10: second write while pending replaces the first
    cur_req = "R10";
    drv(1, 1, 8'h00);
    for (int i = 0; i < 40; i++) drv(1, 0, 8'h00);
    drv(1, 1, 8'h80);
    drv(1, 0, 8'h00);
    drv(1, 1, 8'h00);
    for (int i = 0; i < 8; i++) begin
      drv(1, 0, 8'h00);
      @(negedge clk);
      chk("R10", half_clk, 0);
    end

    // R9: gapped enables with external interrupt pulses
    cur_req = "R9";
    for (int i = 0; i < 240; i++) begin
      ext_irq = (i % 37 == 5);
      drv(i % 3 == 0, 0, 8'h00);
    end
    for (int i = 0; i < 6; i++) drv(0, 0, 8'h00);
    @(negedge clk);
    chk("R11", qtr_clk, 0);

    // R8: external request reaches the line
    cur_req = "R8";
    ext_irq = 1'b1;
    drv(0, 0, 8'h00);
    @(negedge clk);
    chk("R8", irq_out, 1);
    ext_irq = 1'b0;
    drv(0, 0, 8'h00);
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule